// File: doc/BRIEF.md
# Runt-Free Output Clock Gate

This block sits between a bank of already-generated clocks and their output pins. It passes or blocks each clock individually. Every lane has a run request, which turns the clock on or off, and a mode bit, which decides when that request takes effect.

With the mode bit set, the lane switches in step with its own clock. The request crosses into that clock's domain through a short synchronizer. It is then captured while the clock is low, so the output only ever starts or stops between whole pulses. With the mode bit clear, the lane follows the request as soon as the register changes, whatever phase the clock is in.

Both fields live in a small register bank that is written over a plain address/data/strobe port clocked by the system clock. After reset every lane is stopped and in the edge-aligned mode.

Top module: `ocg_bank`

## Requirements
- R1: The block has NUM_OUT gated clock outputs, one per source clock. An output is never high while its source clock is low, and a stopped lane holds its output at 0.
- R2: A write with `wr_en` high is taken at the rising edge of `clk`. Address 0 is the mode field and address 1 is the run field. In both fields, bit i controls lane i. A mode bit of 1 selects aligned switching and 0 selects immediate switching. A run bit of 1 lets the clock through.
- R3: After reset, every mode bit is 1 and every run bit is 0, so all outputs are 0 and a first start of any lane is aligned.
- R4: Writes to any address other than 0 and 1 change neither field, whatever the data.
- R5: In immediate mode, a run bit set to 1 makes the output equal the source clock in the same `clk` cycle in which the register updates, with no wait for a source edge.
- R6: In immediate mode, a run bit cleared to 0 forces the output to 0 in that same cycle, even in the middle of a high phase.
- R7: In aligned mode, a start does not act at once. The output stays 0 until the request has passed SYNC_STAGES rising edges and then one falling edge of the source. From the next rising edge onward, the output equals the source clock.
- R8: In aligned mode, a stop does not act at once. The output keeps following the source until the request has passed the same synchronizer and a falling edge of the source. After that it stays 0.
- R9: In aligned mode, every high pulse on an output lasts exactly one high phase of its source. No low pulse is shorter than one low phase of its source.
- R10: Lanes are independent. The mode and run bits of one lane never change the output of another, and a lane whose run bit is 0 stays at 0 while its neighbours run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the register write port |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of every clock |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Register address: 0 selects mode, 1 selects run |
| wr_data | input | NUM_OUT | Write data, one bit per lane |
| src_clk_i | input | NUM_OUT | Source clocks, one per lane |
| clk_o | output | NUM_OUT | Gated output clocks |

## Verification
The bench builds the block with NUM_OUT = 4 and ADDR_W = 2. Each of the four source clocks runs at a different period, offset from the system clock edges, so every lane meets its own phase relation to the register updates.

With four lanes, the bench can sweep all sixteen mode combinations, each with a full-bank and a partial run pattern. This covers every mix of aligned and immediate lanes, and lanes left stopped beside running ones.

The two-bit address reaches the two unused addresses, so stray writes can be shown to leave both fields intact. A pulse-width monitor on every output times each aligned high and low pulse against its own source's half period.

// File: rtl/ocg_pkg.sv
`timescale 1ns/1ps
package ocg_pkg;

    // Register addresses; the write port decodes only these two.
    localparam int unsigned ADDR_MODE = 0;
    localparam int unsigned ADDR_RUN  = 1;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_RUN
    } reg_sel_e;

    // Per-lane control handed from the register bank to a gate lane.
    typedef struct packed {
        logic sync_mode;   // 1: switch at period boundary, 0: switch at once
        logic run_req;     // 1: pass the clock
    } lane_ctrl_t;

    function automatic reg_sel_e decode_addr(input int unsigned addr);
        if (addr == ADDR_MODE) return SEL_MODE;
        if (addr == ADDR_RUN)  return SEL_RUN;
        return SEL_NONE;
    endfunction

endpackage

// File: rtl/ocg_regs.sv
`timescale 1ns/1ps
module ocg_regs #(
    parameter int NUM_OUT = 8,
    parameter int ADDR_W  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [NUM_OUT-1:0] wr_data,
    output logic [NUM_OUT-1:0] mode_q,
    output logic [NUM_OUT-1:0] en_q
);
    import ocg_pkg::*;

    reg_sel_e sel;

    always_comb begin
        sel = decode_addr(32'(wr_addr));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '1;
            en_q   <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_MODE: mode_q <= wr_data;
                SEL_RUN:  en_q   <= wr_data;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/ocg_sync.sv
`timescale 1ns/1ps
module ocg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe[0] <= d;
            for (int k = 1; k < STAGES; k++) begin
                pipe[k] <= pipe[k-1];
            end
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/ocg_lane.sv
`timescale 1ns/1ps
module ocg_lane #(
    parameter int SYNC_STAGES = 2
) (
    input  logic               src_clk,
    input  logic               rst,
    input  ocg_pkg::lane_ctrl_t ctrl,
    output logic               clk_o
);
    logic req_s;
    logic gate_q;

    // Bring the run request into the source clock domain.
    ocg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (src_clk),
        .rst (rst),
        .d   (ctrl.run_req),
        .q   (req_s)
    );

    // Capture on the falling edge: the gate moves only while the clock is low.
    always_ff @(negedge src_clk) begin
        if (rst) gate_q <= 1'b0;
        else     gate_q <= req_s;
    end

    always_comb begin
        clk_o = src_clk & (ctrl.sync_mode ? gate_q : ctrl.run_req);
    end

endmodule

// File: rtl/ocg_bank.sv
`timescale 1ns/1ps
module ocg_bank #(
    parameter int NUM_OUT     = 8,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [NUM_OUT-1:0] wr_data,
    input  logic [NUM_OUT-1:0] src_clk_i,
    output logic [NUM_OUT-1:0] clk_o
);
    import ocg_pkg::*;

    logic [NUM_OUT-1:0] mode_q;
    logic [NUM_OUT-1:0] en_q;
    lane_ctrl_t         ctrl [NUM_OUT];

    ocg_regs #(.NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .mode_q  (mode_q),
        .en_q    (en_q)
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
        assign ctrl[i].sync_mode = mode_q[i];
        assign ctrl[i].run_req   = en_q[i];

        ocg_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
            .src_clk (src_clk_i[i]),
            .rst     (rst),
            .ctrl    (ctrl[i]),
            .clk_o   (clk_o[i])
        );
    end

endmodule

// File: rtl/ocg_checker.sv
`timescale 1ns/1ps
module ocg_checker #(
    parameter int NUM_OUT = 8,
    parameter int ADDR_W  = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [NUM_OUT-1:0] wr_data,
    input logic [NUM_OUT-1:0] src_clk_i,
    input logic [NUM_OUT-1:0] clk_o,
    input logic [NUM_OUT-1:0] mode_q,
    input logic [NUM_OUT-1:0] en_q
);
    import ocg_pkg::*;

    AST_HIGH_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (clk_o & ~src_clk_i) == '0);                                       // R1

    AST_RUN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(ADDR_RUN)) |=> en_q == $past(wr_data)); // R2

    AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mode_q == '1 && en_q == '0));                      // R3

    AST_STRAY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr > ADDR_W'(ADDR_RUN)) |=> ($stable(mode_q) && $stable(en_q))); // R4

    AST_IMMEDIATE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        ((clk_o ^ src_clk_i) & ~mode_q & en_q) == '0);                     // R5

    AST_IMMEDIATE_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (clk_o & ~mode_q & ~en_q) == '0);                                  // R6

endmodule

bind ocg_bank ocg_checker #(.NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .src_clk_i (src_clk_i),
    .clk_o     (clk_o),
    .mode_q    (mode_q),
    .en_q      (en_q)
);

// File: tb/sim_ocg_bank.sv
`timescale 1ns/1ps
module sim_ocg_bank;
    localparam int NO = 4;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [NO-1:0] wr_data = '0;
    logic [NO-1:0] src;
    logic [NO-1:0] clk_o;

    logic [NO-1:0] mode_sh = '1;
    logic          mon_on = 1'b0;
    int            n_chk = 0;
    int            n_fail = 0;

    ocg_bank #(.NUM_OUT(NO), .ADDR_W(AW), .SYNC_STAGES(2)) u0 (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .src_clk_i (src),
        .clk_o     (clk_o)
    );

    always #4 clk = ~clk;   // 125 MHz

    function automatic real half_of(input int g);
        return (g == 3) ? 9.0 : 5.0 + real'(g);
    endfunction

    task automatic chk(input bit ok, input string rq, input string detail);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", rq, detail);
        end
    endtask

    // Source clocks, offset from the system clock edges.
    for (genvar g = 0; g < NO; g++) begin : g_src
        logic c = 1'b0;
        initial begin
            #0.3;
            forever #(half_of(g)) c = ~c;
        end
        assign src[g] = c;

        // Pulse-width monitor for aligned lanes (R9)
        real  t_last = 0.0;
        logic m_last = 1'b0;
        bit   have = 1'b0;
        always @(clk_o[g]) begin
            if (!mon_on) begin
                have = 1'b0;
            end else begin
                if (have && m_last && mode_sh[g]) begin
                    real w;
                    w = $realtime - t_last;
                    if (clk_o[g] === 1'b0)
                        chk((w > half_of(g) - 0.01) && (w < half_of(g) + 0.01), "R9",
                            $sformatf("lane %0d high width act=%0.3f exp=%0.3f", g, w, half_of(g)));
                    else
                        chk(w > half_of(g) - 0.01, "R9",
                            $sformatf("lane %0d low width act=%0.3f exp>=%0.3f", g, w, half_of(g)));
                end
                have   = 1'b1;
                t_last = $realtime;
                m_last = mode_sh[g];
            end
        end
    end

    task automatic wr(input int a, input logic [NO-1:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = AW'(a);
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // follow[g]=1: output must equal the source; 0: output must be 0.
    task automatic expect_lanes(input logic [NO-1:0] follow, input string rq_on, input string rq_off);
        for (int g = 0; g < NO; g++) begin
            logic e;
            e = follow[g] ? src[g] : 1'b0;
            chk(clk_o[g] === e, follow[g] ? rq_on : rq_off,
                $sformatf("lane %0d act=%b exp=%b", g, clk_o[g], e));
        end
    endtask

    task automatic run_all();
        repeat (10) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        mon_on = 1'b1;
        #40;
        expect_lanes('0, "R3", "R3");                // all stopped after reset
        // First start after reset is aligned (R3, R7)
        wr(1, '1);
        expect_lanes('0, "R3", "R7");
        #90;
        for (int k = 0; k < 4; k++) begin #3; expect_lanes('1, "R7", "R7"); end
        wr(1, '0);
        expect_lanes('1, "R8", "R8");
        #90;
        expect_lanes('0, "R8", "R8");

        // Sweep every mode mix with full and partial run patterns
        for (int m = 0; m < 16; m++) begin
            wr(0, NO'(m));
            mode_sh = NO'(m);
            #40;
            for (int p = 0; p < 2; p++) begin
                logic [NO-1:0] e;
                e = (p == 0) ? 4'hF : (NO'(m) ^ 4'h6);
                wr(1, e);
                expect_lanes(e & ~NO'(m), "R5", (p == 0) ? "R7" : "R10");
                #90;
                for (int k = 0; k < 5; k++) begin #3; expect_lanes(e, "R2", "R10"); end
                #100;
                wr(1, '0);
                expect_lanes(e & NO'(m), "R8", "R6");
                #90;
                expect_lanes('0, "R8", "R6");
            end
        end

        // Stray addresses must leave both fields alone (R4)
        wr(0, 4'b0011);
        mode_sh = 4'b0011;
        #40;
        wr(1, '1);
        #90;
        wr(2, '0);
        wr(3, '1);
        for (int k = 0; k < 4; k++) begin #3; expect_lanes('1, "R4", "R4"); end
        wr(1, '0);
        expect_lanes(4'b0011, "R4", "R4");
        #90;
        expect_lanes('0, "R4", "R4");
    endtask

    initial begin
        bit timed_out;
        timed_out = 1'b0;
        fork
            run_all();
            begin #1ms; timed_out = 1'b1; end
        join_any
        disable fork;
        if (timed_out) chk(1'b0, "watchdog", "act=expired exp=completed");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule